// File: doc/BRIEF.md
# Byte-Lane Load/Store Data Memory

This block is the data-side storage of a small 32-bit core. It holds a flat array of byte cells and serves one access per cycle. A 3-bit size code selects the access type. On a store it picks which bytes of the write word are kept. On a load it picks how the fetched bytes are widened to 32 bits. Multi-byte values are held least significant byte first.

The core drives a byte address, the write word, the size code and two enables. Stores land on the rising clock edge. Loads are combinational, so the read word is valid in the same cycle as the address. The byte address is cut down to the array depth. An access that is not aligned, or that runs past the last cell, simply takes the next consecutive cells, wrapping back to cell 0.

Top module: `dmem_top`

## Requirements
- R1: While the read enable is low, the read data output is all zeros, whatever the memory holds and whatever the other inputs are.
- R2: The memory changes only on a rising clock edge with the write enable high, and only for store size codes 000, 001 and 010. Codes 011 and 100 to 111 write nothing.
- R3: A store with size code 000 writes write-data bits [7:0] into the cell at the address and leaves every other cell as it was.
- R4: A store with size code 001 writes bits [7:0] to the cell at the address and bits [15:8] to the cell at address+1, and nothing else.
- R5: A store with size code 010 writes bits [7:0], [15:8], [23:16] and [31:24] to the cells at address, +1, +2 and +3.
- R6: A load with size code 000 returns the cell at the address sign-extended from bit 7. Size code 100 returns that cell zero-extended.
- R7: A load with size code 001 returns the cells at address+1 (bits [15:8]) and address (bits [7:0]) sign-extended from bit 15. Size code 101 returns the same pair zero-extended.
- R8: A load with size code 010 returns the cells at address+3, +2, +1 and +0 as bits [31:24], [23:16], [15:8] and [7:0].
- R9: A load with size code 011, 110 or 111 returns zero.
- R10: Loads are combinational. With both enables high on the same address, the read data shows the old contents until the clock edge and the stored value right after it.
- R11: Only the low DEPTH_LOG2 address bits select a cell. A multi-byte access uses consecutive cells from the address whatever its alignment, and wraps from the last cell to cell 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores take effect on its rising edge |
| wrEn | input | 1 | Store enable |
| rdEn | input | 1 | Load enable; output is zero when low |
| addr | input | ADDR_W | Byte address; upper bits beyond the depth are ignored |
| wrData | input | 32 | Store data, taken from its low lanes |
| funct3 | input | 3 | Access size and extension code |
| rdData | output | 32 | Load result after extension |

## Verification
A store and a load can fall in the same cycle, and on the same cells. The read path is combinational, so the load must see the old contents before the edge and the new ones after it. The bench raises both enables at once on one word address. It samples the output shortly after the falling edge, while the store is still pending. It samples again just after the rising edge that commits the store. It expects the previous word first and the new word second.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int LANES = 4;

  localparam logic [2:0] SZ_BYTE  = 3'b000;
  localparam logic [2:0] SZ_HALF  = 3'b001;
  localparam logic [2:0] SZ_WORD  = 3'b010;
  localparam logic [2:0] SZ_BYTEU = 3'b100;
  localparam logic [2:0] SZ_HALFU = 3'b101;

  typedef enum logic [2:0] {
    LD_NONE,
    LD_BYTE_S,
    LD_BYTE_U,
    LD_HALF_S,
    LD_HALF_U,
    LD_WORD
  } loadKind_e;

  typedef struct packed {
    logic [LANES-1:0] laneWe;
    logic             rdActive;
    loadKind_e        kind;
  } dmemStrobes_t;

endpackage

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
(
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [2:0]   funct3,
  output dmemStrobes_t strobes
);

  logic [LANES-1:0] laneMask;
  loadKind_e        kindDec;

  // store width -> active byte lanes
  always_comb begin
    case (funct3)
      SZ_BYTE: laneMask = 4'b0001;
      SZ_HALF: laneMask = 4'b0011;
      SZ_WORD: laneMask = 4'b1111;
      default: laneMask = '0;
    endcase
  end

  // load code -> extension kind
  always_comb begin
    case (funct3)
      SZ_BYTE:  kindDec = LD_BYTE_S;
      SZ_HALF:  kindDec = LD_HALF_S;
      SZ_WORD:  kindDec = LD_WORD;
      SZ_BYTEU: kindDec = LD_BYTE_U;
      SZ_HALFU: kindDec = LD_HALF_U;
      default:  kindDec = LD_NONE;
    endcase
  end

  always_comb begin
    strobes.laneWe   = wrEn ? laneMask : '0;
    strobes.rdActive = rdEn;
    strobes.kind     = rdEn ? kindDec : LD_NONE;
  end

endmodule

// File: rtl/dmem_datapath.sv
module dmem_datapath
  import dmem_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  dmemStrobes_t          strobes,
  input  logic [DEPTH_LOG2-1:0] base,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [7:0]            cells [DEPTH];
  logic [DEPTH_LOG2-1:0] laneIdx [LANES];
  logic [7:0]            laneByte [LANES];
  logic [31:0]           rawWord;

  // each lane addresses its own cell; the add wraps at the depth
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign laneIdx[lane]         = base + DEPTH_LOG2'(lane);
    assign laneByte[lane]        = cells[laneIdx[lane]];
    assign rawWord[8*lane +: 8]  = laneByte[lane];
  end

  always_ff @(posedge clk) begin
    for (int lane = 0; lane < LANES; lane++) begin
      if (strobes.laneWe[lane]) cells[laneIdx[lane]] <= wrData[8*lane +: 8];
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdActive) begin
      case (strobes.kind)
        LD_BYTE_S: rdData = {{24{rawWord[7]}}, rawWord[7:0]};
        LD_BYTE_U: rdData = {24'b0, rawWord[7:0]};
        LD_HALF_S: rdData = {{16{rawWord[15]}}, rawWord[15:0]};
        LD_HALF_U: rdData = {16'b0, rawWord[15:0]};
        LD_WORD:   rdData = rawWord;
        default:   rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/dmem_top.sv
module dmem_top
  import dmem_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [2:0]        funct3,
  output logic [31:0]       rdData
);

  dmemStrobes_t          strobes;
  logic [DEPTH_LOG2-1:0] base;

  assign base = addr[DEPTH_LOG2-1:0];

  if (ADDR_W > DEPTH_LOG2) begin : g_hi
    logic unusedAddrHigh;
    assign unusedAddrHigh = ^addr[ADDR_W-1:DEPTH_LOG2];
  end

  dmem_ctrl u_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .funct3  (funct3),
    .strobes (strobes)
  );

  dmem_datapath #(.DEPTH_LOG2(DEPTH_LOG2)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .base    (base),
    .wrData  (wrData),
    .rdData  (rdData)
  );

endmodule

// File: rtl/dmem_checker.sv
module dmem_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [2:0]        funct3,
  input logic [31:0]       rdData
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!armed)
    !rdEn |-> rdData == 32'b0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!armed)
    (rdEn && $past(rdEn) && !$past(wrEn) && $stable(addr) && $stable(funct3))
      |-> $stable(rdData));

  p_byte_roundtrip_r3: assert property (@(posedge clk) disable iff (!armed)
    (wrEn && funct3 == 3'b000) |=>
      (!(rdEn && funct3 == 3'b100 && addr == $past(addr)) ||
       rdData == {24'b0, $past(wrData[7:0])}));

  p_byte_sext_r6: assert property (@(posedge clk) disable iff (!armed)
    (rdEn && funct3 == 3'b000) |-> rdData[31:8] == {24{rdData[7]}});

  p_byte_zext_r6: assert property (@(posedge clk) disable iff (!armed)
    (rdEn && funct3 == 3'b100) |-> rdData[31:8] == 24'b0);

  p_half_sext_r7: assert property (@(posedge clk) disable iff (!armed)
    (rdEn && funct3 == 3'b001) |-> rdData[31:16] == {16{rdData[15]}});

  p_half_zext_r7: assert property (@(posedge clk) disable iff (!armed)
    (rdEn && funct3 == 3'b101) |-> rdData[31:16] == 16'b0);

  p_bad_load_zero_r9: assert property (@(posedge clk) disable iff (!armed)
    (rdEn && (funct3 == 3'b011 || funct3 == 3'b110 || funct3 == 3'b111))
      |-> rdData == 32'b0);

endmodule

bind dmem_top dmem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .wrData (wrData),
  .funct3 (funct3),
  .rdData (rdData)
);

// File: tb/test_dmem_top.sv
module test_dmem_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  funct3 = '0;
  logic [31:0] rdData;

  int errCnt = 0;
  int chkCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_top i_dmem_top (
    .clk    (clk),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .funct3 (funct3),
    .rdData (rdData)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic store(logic [31:0] a, logic [31:0] d, logic [2:0] f3);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b0; addr = a; wrData = d; funct3 = f3;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic load(logic [31:0] a, logic [2:0] f3, logic [31:0] exp, string req);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b1; addr = a; funct3 = f3;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic t_idle;
    check("R1 start", rdData, 32'h0);
    store(32'h10, 32'h8BAD_F00D, 3'b010);
    @(negedge clk);
    rdEn = 1'b0; addr = 32'h10; funct3 = 3'b010;
    #1;
    check("R1 disabled read", rdData, 32'h0);
  endtask

  task automatic t_word;
    load(32'h10, 3'b010, 32'h8BAD_F00D, "R5/R8 word");
    load(32'h10, 3'b100, 32'h0000_000D, "R6 lbu low");
    load(32'h13, 3'b100, 32'h0000_008B, "R6 lbu high");
    load(32'h13, 3'b000, 32'hFFFF_FF8B, "R6 lb neg");
  endtask

  task automatic t_byte;
    store(32'h20, 32'h1122_3344, 3'b010);
    store(32'h21, 32'hAABB_CCF0, 3'b000);
    load(32'h20, 3'b010, 32'h1122_F044, "R3 sb lane");
    load(32'h21, 3'b000, 32'hFFFF_FFF0, "R6 lb");
    load(32'h21, 3'b100, 32'h0000_00F0, "R6 lbu");
  endtask

  task automatic t_half;
    store(32'h30, 32'h0, 3'b010);
    store(32'h32, 32'h1234_8765, 3'b001);
    load(32'h30, 3'b010, 32'h8765_0000, "R4 sh lanes");
    load(32'h32, 3'b001, 32'hFFFF_8765, "R7 lh neg");
    load(32'h32, 3'b101, 32'h0000_8765, "R7 lhu");
    load(32'h30, 3'b001, 32'h0000_0000, "R7 lh zero");
  endtask

  task automatic t_no_write;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; addr = 32'h30; wrData = 32'hFFFF_FFFF; funct3 = 3'b010;
    @(negedge clk);
    load(32'h30, 3'b010, 32'h8765_0000, "R2 wrEn low");
    store(32'h20, 32'h0, 3'b011);
    store(32'h20, 32'h0, 3'b100);
    store(32'h20, 32'h0, 3'b111);
    load(32'h20, 3'b010, 32'h1122_F044, "R2 bad store code");
  endtask

  task automatic t_bad_load;
    load(32'h20, 3'b011, 32'h0, "R9 code 011");
    load(32'h20, 3'b110, 32'h0, "R9 code 110");
    load(32'h20, 3'b111, 32'h0, "R9 code 111");
  endtask

  task automatic t_misaligned;
    store(32'h14, 32'h4433_2211, 3'b010);
    load(32'h11, 3'b010, 32'h118B_ADF0, "R11 misaligned word");
    load(32'h13, 3'b001, 32'h0000_118B, "R11 misaligned lh");
    load(32'h12, 3'b101, 32'h0000_8BAD, "R11 misaligned lhu");
  endtask

  task automatic t_wrap;
    store(32'h3FE, 32'hA1B2_C3D4, 3'b010);
    load(32'h000, 3'b101, 32'h0000_A1B2, "R11 wrap to zero");
    load(32'h3FE, 3'b010, 32'hA1B2_C3D4, "R11 wrap word");
    load(32'h0000_33FE, 3'b010, 32'hA1B2_C3D4, "R11 high bits ignored");
  endtask

  task automatic t_same_cycle;
    store(32'h40, 32'h0102_0304, 3'b010);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 32'h40; wrData = 32'hCAFE_BABE; funct3 = 3'b010;
    #1;
    check("R10 before edge", rdData, 32'h0102_0304);
    @(posedge clk);
    #1;
    check("R10 after edge", rdData, 32'hCAFE_BABE);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog (all): actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    #1;
    t_idle();
    t_word();
    t_byte();
    t_half();
    t_no_write();
    t_bad_load();
    t_misaligned();
    t_wrap();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule